// File: doc/BRIEF.md
# Physical Memory Protection Checker

This block decides whether a physical memory access may proceed. It holds a small set of protection entries. Each entry has one address register and one 8-bit configuration byte. Each request carries a byte address, an access kind (read, write or execute) and the effective privilege level. One clock later the block returns allow or deny. Software programs the entries through a register-style write port and reads them back through a combinational read port. Address registers are written one at a time. Configuration bytes are packed four to a 32-bit word.

An entry matches addresses in one of three ways. In top-of-range mode it covers the span from the previous entry's address up to its own address. The other two modes cover a naturally aligned 4-byte word or a naturally aligned power-of-two region. If several entries match, the entry with the lowest number decides. Software can only change an entry's mode by rewriting the whole shared configuration word, so an entry's address and its mode never change in the same write. For this reason, a top-of-range entry whose base is not below its top matches no address at all. The half-finished states that software passes through during an update therefore never produce a match.

Top module: `pmp_checker`

## Requirements
- R1: After reset every address register and configuration word reads back zero and respValid is low. With all entries off, a request at privilege code 0 (user) is denied and a request at privilege code 3 (machine) is allowed.
- R2: A write with csrWrSel=0 stores csrWrData as-is into the address register numbered csrWrIdx. A write with csrWrSel=1 stores it into configuration word csrWrIdx. In that word, the byte at bits [8b+7:8b] belongs to entry 4*csrWrIdx+b. Reading back with the same select and index returns exactly the stored bits, reserved bits included.
- R3: Configuration byte bits [4:3] select the match mode: 0 off, 1 top-of-range, 2 aligned 4-byte, 3 aligned power-of-two. In top-of-range mode, entry i matches a byte address A when prev*4 <= A < addr[i]*4. Here prev is addr[i-1], or zero for entry 0.
- R4: A top-of-range entry whose base register is greater than or equal to its own address register matches no address. This holds in every intermediate state of an update that first writes the address registers and then changes the modes by rewriting the configuration word.
- R5: In aligned 4-byte mode an entry matches exactly the bytes addr*4 through addr*4+3.
- R6: In aligned power-of-two mode, let k be the number of trailing one bits in the address register. The entry then matches the 2^(k+3)-byte region that contains addr*4 and is aligned to its own size.
- R7: An entry whose mode is off matches no address, whatever its address register holds.
- R8: When several entries match, the lowest-numbered one alone decides the result.
- R9: Configuration bit 0 permits reads, bit 1 writes and bit 2 execute. Access kind codes are 0 read, 1 write and 2 execute. A code of 3 matches no permission and is denied by any entry that enforces.
- R10: At machine privilege, an entry that matches but is unlocked grants the access whatever its permission bits, and an access that matches no entry is allowed. At user (0) or supervisor (1) privilege, an access that matches no entry is denied.
- R11: Configuration bit 7 locks an entry. Once the bit is set, writes to that entry's address register and to its configuration byte are ignored, while the other bytes of the same word still take the write. A locked entry enforces its permission bits at machine privilege too. Only reset clears the lock.
- R12: respValid equals reqValid delayed by one clock. respAllow carries the decision for that request and is low whenever respValid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csrWrEn | input | 1 | Register write strobe |
| csrWrSel | input | 1 | Write target: 0 address register, 1 configuration word |
| csrWrIdx | input | IDX_W (3) | Entry or configuration-word index for the write |
| csrWrData | input | 32 | Write data |
| csrRdSel | input | 1 | Read target: 0 address register, 1 configuration word |
| csrRdIdx | input | IDX_W (3) | Entry or configuration-word index for the read |
| csrRdData | output | 32 | Combinational readback of the selected register |
| reqValid | input | 1 | Access request present |
| reqAddr | input | 34 | Physical byte address |
| reqType | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| reqPriv | input | 2 | Effective privilege: 0 user, 1 supervisor, 3 machine |
| respValid | output | 1 | Decision present (one cycle after the request) |
| respAllow | output | 1 | Access granted |

## Verification
The hardest case to reach is the inverted top-of-range window. It exists only between separate register writes, and from the ports it looks exactly like "no match". To reach it, the stimulus replays a real reprogramming sequence. First it moves the lower neighbour's address above the entry's top, then it moves the top. After that it switches each of the two entries to power-of-two mode with whole-word rewrites. It probes addresses inside the old range, inside the new ranges and at both swapped bounds after every single write. Supervisor privilege is used, so any spurious match would show up as an allow, and the reference model is compared with the outputs on every clock of the sequence.

// File: rtl/pmp_pkg.sv
package pmp_pkg;

  localparam int XLEN         = 32;
  localparam int CFG_PER_WORD = XLEN / 8;
  localparam int STB_IDX_W    = 8;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_TOR   = 2'd1,
    MODE_NA4   = 2'd2,
    MODE_NAPOT = 2'd3
  } matchMode_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2
  } accessKind_e;

  typedef enum logic [1:0] {
    PRIV_USER  = 2'd0,
    PRIV_SUPER = 2'd1,
    PRIV_MACH  = 2'd3
  } privLevel_e;

  // One entry's configuration byte, most significant field first.
  typedef struct packed {
    logic       lock;
    logic [1:0] rsvd;
    matchMode_e mode;
    logic       permX;
    logic       permW;
    logic       permR;
  } entryCfg_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic                    addrWe;
    logic                    cfgWe;
    logic [CFG_PER_WORD-1:0] byteEn;
    logic [STB_IDX_W-1:0]    idx;
    logic [XLEN-1:0]         data;
    logic                    capture;
  } pmpStrobe_t;

endpackage

// File: rtl/pmp_entry_match.sv
module pmp_entry_match
  import pmp_pkg::*;
#(
  parameter int ADDR_REG_W = 32
) (
  input  matchMode_e              mode,
  input  logic [ADDR_REG_W-1:0]   baseReg,
  input  logic [ADDR_REG_W-1:0]   topReg,
  input  logic [ADDR_REG_W+1:0]   addr,
  output logic                    hit
);

  localparam int PA_W = ADDR_REG_W + 2;

  logic [PA_W-1:0]       baseByte;
  logic [PA_W-1:0]       topByte;
  logic                  torOrdered;
  logic                  torHit;
  logic                  na4Hit;
  logic [ADDR_REG_W-1:0] napotMask;
  logic                  napotHit;

  assign baseByte = {baseReg, 2'b00};
  assign topByte  = {topReg, 2'b00};

  // An inverted or empty window is rejected outright.
  assign torOrdered = baseReg < topReg;
  assign torHit     = torOrdered && (addr >= baseByte) && (addr < topByte);

  assign na4Hit = addr[PA_W-1:2] == topReg;

  // Trailing ones plus the next zero mark the bits that are ignored.
  assign napotMask = topReg ^ (topReg + 1'b1);
  assign napotHit  = ((addr[PA_W-1:2] ^ topReg) & ~napotMask) == '0;

  always_comb begin
    unique case (mode)
      MODE_TOR:   hit = torHit;
      MODE_NA4:   hit = na4Hit;
      MODE_NAPOT: hit = napotHit;
      default:    hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/pmp_ctrl.sv
module pmp_ctrl
  import pmp_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   csrWrEn,
  input  logic                   csrWrSel,
  input  logic [IDX_W-1:0]       csrWrIdx,
  input  logic [XLEN-1:0]        csrWrData,
  input  logic                   reqValid,
  input  logic [NUM_ENTRIES-1:0] lockVec,
  output pmpStrobe_t             strobe,
  output logic                   respValid
);

  localparam int CFG_WORDS = NUM_ENTRIES / CFG_PER_WORD;

  logic                    addrLocked;
  logic                    wordInRange;
  logic [CFG_PER_WORD-1:0] wordLocks;

  // Lock state of the targeted entry and configuration word.
  always_comb begin
    addrLocked  = 1'b0;
    wordInRange = 1'b0;
    wordLocks   = '1;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (csrWrIdx == IDX_W'(i)) addrLocked = lockVec[i];
    end
    for (int w = 0; w < CFG_WORDS; w++) begin
      if (csrWrIdx == IDX_W'(w)) begin
        wordInRange = 1'b1;
        wordLocks   = lockVec[w*CFG_PER_WORD +: CFG_PER_WORD];
      end
    end
  end

  always_comb begin
    strobe         = '0;
    strobe.idx     = STB_IDX_W'(csrWrIdx);
    strobe.data    = csrWrData;
    strobe.capture = reqValid;
    if (csrWrEn && !csrWrSel && !addrLocked) begin
      strobe.addrWe = 1'b1;
    end
    if (csrWrEn && csrWrSel && wordInRange) begin
      strobe.byteEn = ~wordLocks;
      strobe.cfgWe  = |(~wordLocks);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) respValid <= 1'b0;
    else       respValid <= reqValid;
  end

endmodule

// File: rtl/pmp_datapath.sv
module pmp_datapath
  import pmp_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int IDX_W       = $clog2(NUM_ENTRIES),
  parameter int PA_W        = XLEN + 2
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  pmpStrobe_t                        strobe,
  input  logic [PA_W-1:0]                   reqAddr,
  input  logic [1:0]                        reqType,
  input  logic [1:0]                        reqPriv,
  input  logic                              rdSel,
  input  logic [IDX_W-1:0]                  rdIdx,
  output logic [XLEN-1:0]                   rdData,
  output logic [NUM_ENTRIES-1:0]            lockVec,
  output logic [NUM_ENTRIES-1:0][XLEN-1:0]  addrQ,
  output logic                              respAllow
);

  localparam int CFG_WORDS = NUM_ENTRIES / CFG_PER_WORD;

  logic [NUM_ENTRIES-1:0][7:0] cfgQ;
  logic [NUM_ENTRIES-1:0]      hitVec;
  logic                        anyHit;
  logic                        winLock;
  logic                        winR;
  logic                        winW;
  logic                        winX;
  logic                        permOk;
  logic                        allowComb;

  // Register storage, kept exactly as written.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ     <= '0;
      cfgQ      <= '0;
      respAllow <= 1'b0;
    end else begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        if (strobe.addrWe && strobe.idx == STB_IDX_W'(i)) addrQ[i] <= strobe.data;
      end
      for (int w = 0; w < CFG_WORDS; w++) begin
        for (int b = 0; b < CFG_PER_WORD; b++) begin
          if (strobe.cfgWe && strobe.byteEn[b] && strobe.idx == STB_IDX_W'(w)) begin
            cfgQ[w*CFG_PER_WORD+b] <= strobe.data[b*8 +: 8];
          end
        end
      end
      respAllow <= strobe.capture & allowComb;
    end
  end

  // Per-entry matchers.
  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : gEntry
    entryCfg_t             entCfg;
    logic [XLEN-1:0]       baseReg;
    assign entCfg     = entryCfg_t'(cfgQ[i]);
    assign lockVec[i] = entCfg.lock;
    if (i == 0) begin : gFirst
      assign baseReg = '0;
    end else begin : gRest
      assign baseReg = addrQ[i-1];
    end
    pmp_entry_match #(.ADDR_REG_W(XLEN)) uMatch (
      .mode    (entCfg.mode),
      .baseReg (baseReg),
      .topReg  (addrQ[i]),
      .addr    (reqAddr),
      .hit     (hitVec[i])
    );
  end

  // Lowest-numbered hit wins.
  always_comb begin
    anyHit  = 1'b0;
    winLock = 1'b0;
    winR    = 1'b0;
    winW    = 1'b0;
    winX    = 1'b0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (hitVec[i]) begin
        anyHit  = 1'b1;
        winLock = cfgQ[i][7];
        winX    = cfgQ[i][2];
        winW    = cfgQ[i][1];
        winR    = cfgQ[i][0];
      end
    end
  end

  always_comb begin
    unique case (reqType)
      ACC_READ:  permOk = winR;
      ACC_WRITE: permOk = winW;
      ACC_EXEC:  permOk = winX;
      default:   permOk = 1'b0;
    endcase
  end

  always_comb begin
    if (anyHit) begin
      if (reqPriv == PRIV_MACH && !winLock) allowComb = 1'b1;
      else                                  allowComb = permOk;
    end else begin
      allowComb = (reqPriv == PRIV_MACH);
    end
  end

  // Readback.
  always_comb begin
    rdData = '0;
    if (!rdSel) begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        if (rdIdx == IDX_W'(i)) rdData = addrQ[i];
      end
    end else begin
      for (int w = 0; w < CFG_WORDS; w++) begin
        if (rdIdx == IDX_W'(w)) rdData = cfgQ[w*CFG_PER_WORD +: CFG_PER_WORD];
      end
    end
  end

endmodule

// File: rtl/pmp_checker.sv
module pmp_checker
  import pmp_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int IDX_W       = $clog2(NUM_ENTRIES),
  parameter int PA_W        = XLEN + 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csrWrEn,
  input  logic             csrWrSel,
  input  logic [IDX_W-1:0] csrWrIdx,
  input  logic [31:0]      csrWrData,
  input  logic             csrRdSel,
  input  logic [IDX_W-1:0] csrRdIdx,
  output logic [31:0]      csrRdData,
  input  logic             reqValid,
  input  logic [PA_W-1:0]  reqAddr,
  input  logic [1:0]       reqType,
  input  logic [1:0]       reqPriv,
  output logic             respValid,
  output logic             respAllow
);

  pmpStrobe_t                       strobe;
  logic [NUM_ENTRIES-1:0]           lockVec;
  logic [NUM_ENTRIES-1:0][XLEN-1:0] addrQ;

  pmp_ctrl #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .csrWrEn   (csrWrEn),
    .csrWrSel  (csrWrSel),
    .csrWrIdx  (csrWrIdx),
    .csrWrData (csrWrData),
    .reqValid  (reqValid),
    .lockVec   (lockVec),
    .strobe    (strobe),
    .respValid (respValid)
  );

  pmp_datapath #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W), .PA_W(PA_W)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .reqAddr   (reqAddr),
    .reqType   (reqType),
    .reqPriv   (reqPriv),
    .rdSel     (csrRdSel),
    .rdIdx     (csrRdIdx),
    .rdData    (csrRdData),
    .lockVec   (lockVec),
    .addrQ     (addrQ),
    .respAllow (respAllow)
  );

endmodule

// File: rtl/pmp_checker_sva.sv
module pmp_checker_sva #(
  parameter int NUM_ENTRIES = 8
) (
  input logic                              clk,
  input logic                              rstN,
  input logic                              reqValid,
  input logic [1:0]                        reqPriv,
  input logic                              respValid,
  input logic                              respAllow,
  input logic [NUM_ENTRIES-1:0]            lockVec,
  input logic [NUM_ENTRIES-1:0][31:0]      addrQ
);

  a_r12_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> respValid);

  a_r12_idle_follows: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !respValid);

  a_r12_allow_needs_valid: assert property (@(posedge clk) disable iff (!rstN)
    !respValid |-> !respAllow);

  // R10: machine privilege with no locked entry is always granted.
  a_r10_machine_open: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqPriv == 2'd3 && lockVec == '0) |=> respAllow);

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : gLock
    a_r11_lock_sticky: assert property (@(posedge clk) disable iff (!rstN)
      lockVec[i] |=> lockVec[i]);
    a_r11_addr_frozen: assert property (@(posedge clk) disable iff (!rstN)
      lockVec[i] |=> $stable(addrQ[i]));
  end

endmodule

bind pmp_checker pmp_checker_sva #(.NUM_ENTRIES(NUM_ENTRIES)) uSva (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqPriv   (reqPriv),
  .respValid (respValid),
  .respAllow (respAllow),
  .lockVec   (lockVec),
  .addrQ     (addrQ)
);

// File: tb/tb_pmp_checker.sv
`timescale 1ns/1ps
module tb_pmp_checker;

  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csrWrEn = 1'b0;
  logic        csrWrSel = 1'b0;
  logic [2:0]  csrWrIdx = '0;
  logic [31:0] csrWrData = '0;
  logic        csrRdSel = 1'b0;
  logic [2:0]  csrRdIdx = '0;
  logic [31:0] csrRdData;
  logic        reqValid = 1'b0;
  logic [33:0] reqAddr = '0;
  logic [1:0]  reqType = '0;
  logic [1:0]  reqPriv = '0;
  logic        respValid;
  logic        respAllow;

  int    tests = 0;
  int    fails = 0;
  bit    started = 0;
  bit    finished = 0;
  string curTag = "R1";
  string expTag = "R1";

  logic [31:0] mAddr [N];
  logic [7:0]  mCfg  [N];
  bit          expValid = 0;
  bit          expAllow = 0;

  pmp_checker dut (
    .clk(clk), .rstN(rstN), .csrWrEn(csrWrEn), .csrWrSel(csrWrSel),
    .csrWrIdx(csrWrIdx), .csrWrData(csrWrData), .csrRdSel(csrRdSel),
    .csrRdIdx(csrRdIdx), .csrRdData(csrRdData), .reqValid(reqValid),
    .reqAddr(reqAddr), .reqType(reqType), .reqPriv(reqPriv),
    .respValid(respValid), .respAllow(respAllow)
  );

  always #4 clk = ~clk;

  function automatic bit refAllow(longint unsigned a, int t, int p);
    for (int i = 0; i < N; i++) begin
      int mode = int'(mCfg[i][4:3]);
      bit hit = 0;
      longint unsigned lo;
      longint unsigned hi;
      longint unsigned size;
      int k;
      if (mode == 1) begin
        if (i == 0) lo = 0;
        else lo = {32'b0, mAddr[i-1]} * 4;
        hi = {32'b0, mAddr[i]} * 4;
        hit = (a >= lo) && (a < hi);
      end else if (mode == 2) begin
        hit = (a / 4) == {32'b0, mAddr[i]};
      end else if (mode == 3) begin
        k = 0;
        while (k < 32 && mAddr[i][k]) k++;
        size = 64'd1 << (k + 3);
        lo = ({32'b0, mAddr[i]} * 4) & ~(size - 1);
        hit = (a >= lo) && (a < lo + size);
      end
      if (hit) begin
        if (p == 3 && !mCfg[i][7]) return 1;
        case (t)
          0: return mCfg[i][0];
          1: return mCfg[i][1];
          2: return mCfg[i][2];
          default: return 0;
        endcase
      end
    end
    return p == 3;
  endfunction

  // Reference model: decide on the old state, then apply the write.
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < N; i++) begin
        mAddr[i] = '0;
        mCfg[i]  = '0;
      end
      expValid = 0;
      expAllow = 0;
    end else begin
      expValid = reqValid;
      expAllow = reqValid ? refAllow({30'b0, reqAddr}, int'(reqType), int'(reqPriv)) : 1'b0;
      expTag   = curTag;
      if (csrWrEn) begin
        if (!csrWrSel) begin
          if (!mCfg[csrWrIdx][7]) mAddr[csrWrIdx] = csrWrData;
        end else if (csrWrIdx < 3'd2) begin
          for (int b = 0; b < 4; b++) begin
            if (!mCfg[int'(csrWrIdx)*4+b][7]) mCfg[int'(csrWrIdx)*4+b] = csrWrData[b*8 +: 8];
          end
        end
      end
    end
  end

  // Every-cycle comparison of the response against the model.
  always @(negedge clk) begin
    if (started && rstN && !finished) begin
      tests++;
      if (respValid !== expValid || respAllow !== expAllow) begin
        fails++;
        $display("FAIL %s cycle compare: actual valid=%0b allow=%0b expected valid=%0b allow=%0b",
                 expTag, respValid, respAllow, expValid, expAllow);
      end
    end
  end

  task automatic chk(bit ok, string tag, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic csrWrite(bit sel, int idx, logic [31:0] data);
    @(negedge clk);
    csrWrEn   = 1'b1;
    csrWrSel  = sel;
    csrWrIdx  = 3'(idx);
    csrWrData = data;
    @(negedge clk);
    csrWrEn   = 1'b0;
  endtask

  task automatic rdCheck(bit sel, int idx, logic [31:0] exp, string tag);
    @(negedge clk);
    csrRdSel = sel;
    csrRdIdx = 3'(idx);
    #1;
    chk(csrRdData === exp, tag, longint'(csrRdData), longint'(exp));
  endtask

  task automatic access(longint a, int t, int p, bit exp, string tag);
    @(negedge clk);
    curTag   = tag;
    reqValid = 1'b1;
    reqAddr  = 34'(a);
    reqType  = 2'(t);
    reqPriv  = 2'(p);
    @(negedge clk);
    reqValid = 1'b0;
    chk(respValid === 1'b1 && respAllow === exp, tag, longint'(respAllow), longint'(exp));
  endtask

  initial begin
    #800000;
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    started = 1;

    // R1 reset state
    chk(respValid === 1'b0, "R1 respValid", longint'(respValid), 0);
    rdCheck(0, 0, 32'h0, "R1 addr0");
    rdCheck(1, 0, 32'h0, "R1 cfg word0");
    rdCheck(1, 1, 32'h0, "R1 cfg word1");
    access(34'h100, 0, 0, 0, "R1 user nomatch");
    access(34'h100, 0, 3, 1, "R1 machine nomatch");

    // R2 readback exactly as written
    csrWrite(0, 2, 32'h1234_5678);
    rdCheck(0, 2, 32'h1234_5678, "R2 addr2");
    csrWrite(1, 1, 32'h1E0D_0B09);
    rdCheck(1, 1, 32'h1E0D_0B09, "R2 cfg word1");
    csrWrite(1, 1, 32'h0);
    csrWrite(0, 2, 32'h0);

    // R3 top-of-range, entry 0 based at zero
    csrWrite(0, 0, 32'h100);
    csrWrite(1, 0, 32'h0000_0009);
    access(34'h3FC, 0, 0, 1, "R3 tor0 inside");
    access(34'h400, 0, 0, 0, "R3 tor0 top excl");
    access(34'h0,   1, 0, 0, "R9 tor0 no write");
    csrWrite(0, 1, 32'h200);
    csrWrite(1, 0, 32'h0000_0B09);
    access(34'h400, 1, 0, 1, "R3 tor1 base incl");
    access(34'h7FF, 1, 0, 1, "R3 tor1 last byte");
    access(34'h800, 1, 0, 0, "R3 tor1 top excl");

    // R8 priority with overlapping power-of-two region
    csrWrite(0, 2, 32'h1FF);
    csrWrite(1, 0, 32'h001F_0B09);
    access(34'h10,  2, 0, 0, "R8 entry0 wins exec");
    access(34'h100, 1, 0, 0, "R8 entry0 wins write");
    access(34'h900, 2, 0, 1, "R9 exec allowed");
    access(34'h900, 3, 0, 0, "R9 kind3 denied");
    access(34'hFFF, 0, 0, 1, "R6 napot 4KiB top");
    access(34'h1000, 0, 0, 0, "R6 napot 4KiB beyond");

    // R6 smallest power-of-two region
    csrWrite(0, 3, 32'h800);
    csrWrite(1, 0, 32'h191F_0B09);
    access(34'h2004, 0, 0, 1, "R6 napot8 inside");
    access(34'h2008, 0, 0, 0, "R6 napot8 above");
    access(34'h1FFC, 0, 0, 0, "R6 napot8 below");

    // R5 aligned 4-byte
    csrWrite(0, 4, 32'hC00);
    csrWrite(1, 1, 32'h0000_0012);
    access(34'h3003, 1, 0, 1, "R5 na4 last byte");
    access(34'h3004, 1, 0, 0, "R5 na4 next word");
    access(34'h3000, 0, 0, 0, "R5 na4 no read");

    // R4 split update sequence
    csrWrite(0, 5, 32'h4000);
    csrWrite(0, 6, 32'h5000);
    csrWrite(1, 1, 32'h000F_0012);
    access(34'h12000, 0, 1, 1, "R4 initial tor");
    csrWrite(0, 5, 32'h60FF);
    access(34'h12000, 0, 1, 0, "R4 inverted old range");
    access(34'h183FC, 0, 1, 0, "R4 inverted at base");
    access(34'h13FFC, 0, 1, 0, "R4 inverted below top");
    csrWrite(0, 6, 32'h52FF);
    access(34'h14B00, 0, 1, 0, "R4 inverted new top");
    access(34'h18400, 0, 1, 0, "R4 inverted above base");
    csrWrite(1, 1, 32'h000F_1912);
    access(34'h18100, 0, 1, 1, "R4 neighbour napot read");
    access(34'h18100, 1, 1, 0, "R4 neighbour napot write");
    access(34'h14B00, 0, 1, 0, "R4 still inverted");
    csrWrite(1, 1, 32'h001F_1912);
    access(34'h14B00, 1, 1, 1, "R4 final napot");
    access(34'h12000, 0, 1, 0, "R4 old range gone");

    // R7 off entry
    csrWrite(0, 7, 32'hFFFF_FFFF);
    access(34'h3_FFFF_FFF0, 0, 0, 0, "R7 off entry");

    // R10 machine privilege
    access(34'h0, 1, 3, 1, "R10 machine unlocked");
    access(34'h2000_0000, 0, 3, 1, "R10 machine nomatch");
    access(34'h2000_0000, 0, 1, 0, "R10 super nomatch");

    // R11 lock
    csrWrite(1, 0, 32'h991F_0B09);
    access(34'h2000, 1, 3, 0, "R11 locked machine write");
    access(34'h2004, 0, 3, 1, "R11 locked machine read");
    csrWrite(0, 3, 32'h1234);
    rdCheck(0, 3, 32'h800, "R11 addr write ignored");
    csrWrite(1, 0, 32'h0);
    rdCheck(1, 0, 32'h9900_0000, "R11 byte kept others written");
    access(34'h100, 0, 0, 0, "R11 cleared entries");
    access(34'h2000, 0, 0, 1, "R11 locked entry user read");
    access(34'h2004, 1, 3, 0, "R11 still enforced");

    // R12 idle cycle after a request
    @(negedge clk);
    chk(respValid === 1'b0 && respAllow === 1'b0, "R12 idle", longint'({respValid, respAllow}), 0);

    repeat (2) @(negedge clk);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule